// File: doc/BRIEF.md
# Interrupt Status Aggregation Register

This block gathers the event flags of a USB device controller and presents them to a host processor through a small register port. Events arrive from the protocol engine as single-cycle pulses. Each one sets a sticky flag that software clears by writing a zero to its bit; writing a one leaves the flag alone. A control-transfer stage flag collects five stage events. One of them, setup-stage complete, always counts. The other four pass only when their enable bits are set.

Three per-pipe sub-registers hold buffer-ready, buffer-not-ready and buffer-empty/size-error bits. Each sub-register covers the default control pipe and six data pipes. A read-only summary bit per sub-register is the OR of its bits. A summary bit therefore drops only when software has cleared every bit below it. A setup-packet-received flag holds off writes to the control pipe's 2-bit handshake field through a lock output, and it never raises the interrupt.

The interrupt request is a registered, level, active-high OR of the stage flag and the three summary bits, each gated by its own enable. While the clock-enable input is low, writes of zero clear nothing.

Top module: `isr_aggregator`

## Requirements
- R1: After a synchronous reset every flag, sub-register bit and enable bit is 0, and `irq`, `pid_lock` and `reg_rdata` are 0.
- R2: The stage flag (address 0 bit 0) sets on `ev_setup_done` regardless of any enable. It sets on `ev_wr_status`, `ev_rd_status`, `ev_xfer_done` or `ev_seq_err` only when enable bit 0, 1, 2 or 3 of address 1 (read/write) is 1.
- R3: A write to address 0 with bit 0 = 0 clears the stage flag. With bit 0 = 1 the flag is unchanged.
- R4: Addresses 2, 3 and 4 hold the ready, not-ready and empty sub-registers. Bit 0 is the control pipe and bit k is data pipe k. An event pulse sets its bit, a written 0 clears that bit only, and a written 1 leaves it unchanged.
- R5: Address 0 bits 1, 2 and 3 read as the OR of the ready, not-ready and empty sub-registers. Writes do not change them.
- R6: The setup-packet flag (address 0 bit 4) sets on `ev_setup_pkt` and clears on a write of 0 to that bit. A write of 1 is ignored, and the flag never drives `irq`.
- R7: `pid_lock` is 1 exactly while the setup-packet flag is 1.
- R8: While `clk_en` is 0, writes of zero clear no flag or sub-register bit.
- R9: `irq` is 1 one cycle after any of these holds: (stage flag AND enable bit 0 at address 5), (ready summary AND bit 1), (not-ready summary AND bit 2), (empty summary AND bit 3).
- R10: An event pulse in the same cycle as a write-0 clear of the same bit leaves the bit set.
- R11: `reg_rdata` is registered: it shows, one edge after `reg_addr` is presented, the register contents before that edge. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Internal clock enable; low blocks write-0 clears |
| ev_setup_done | input | 1 | Setup stage complete pulse |
| ev_wr_status | input | 1 | Control-write status stage entered pulse |
| ev_rd_status | input | 1 | Control-read status stage entered pulse |
| ev_xfer_done | input | 1 | Control transfer complete pulse |
| ev_seq_err | input | 1 | Control sequence error pulse |
| ev_setup_pkt | input | 1 | Setup packet fully received pulse |
| ev_rdy | input | N_PIPES+1 | Buffer-ready pulses, bit 0 control pipe |
| ev_nrdy | input | N_PIPES+1 | Buffer-not-ready pulses |
| ev_emp | input | N_PIPES+1 | Buffer-empty/size-error pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | N_PIPES+1 | Write data |
| reg_rdata | output | N_PIPES+1 | Registered read data |
| irq | output | 1 | Level interrupt request |
| pid_lock | output | 1 | Blocks writes to the control pipe handshake field |

## Verification
An event pulse or a write presented before edge k changes the flag state at edge k. `pid_lock` follows at the same edge. The `irq` output follows one edge later, at k+1. A read shows the state as it was before the edge at which its address is sampled.

The bench keeps a shadow state that it updates at each edge. Before the edge, it computes the expected `irq` and read data from the state held at that moment. It compares both in the following low clock phase. Directed reads are always made in a separate cycle after the stimulus, so the value they see already includes that stimulus.

// File: rtl/isr_pkg.sv
package isr_pkg;
  // stage cause enable positions (address 1)
  localparam int NUM_CAUSE  = 4;
  localparam int CS_WR_STS  = 0;
  localparam int CS_RD_STS  = 1;
  localparam int CS_DONE    = 2;
  localparam int CS_SEQ_ERR = 3;

  // main status register bit positions (address 0)
  localparam int MB_STAGE  = 0;
  localparam int MB_RDY    = 1;
  localparam int MB_NRDY   = 2;
  localparam int MB_EMP    = 3;
  localparam int MB_SETUP  = 4;
  localparam int MAIN_BITS = 5;

  // register addresses
  localparam int RA_MAIN   = 0;
  localparam int RA_STG_EN = 1;
  localparam int RA_RDY    = 2;
  localparam int RA_NRDY   = 3;
  localparam int RA_EMP    = 4;
  localparam int RA_IRQ_EN = 5;

  localparam int NUM_BANK  = 3;
  localparam int IE_BITS   = 4;
endpackage

// File: rtl/isr_flag_bank.sv
// Sticky flags: set by pulse, cleared by written zero, set wins.
module isr_flag_bank #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clk_en,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_mask;

  always_comb begin
    clr_mask = (clr_we && clk_en) ? ~clr_data : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= set_i | (q & ~clr_mask);
  end
endmodule

// File: rtl/isr_stage_gate.sv
// Qualifies stage events: setup completion always passes.
module isr_stage_gate #(
  parameter int NC = 4
) (
  input  logic          setup_ev,
  input  logic [NC-1:0] cause_ev,
  input  logic [NC-1:0] cause_en,
  output logic          stage_set
);
  always_comb begin
    stage_set = setup_ev | (|(cause_ev & cause_en));
  end
endmodule

// File: rtl/isr_read_mux.sv
// Registered read data selection.
module isr_read_mux
  import isr_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 7
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [AW-1:0]                 addr,
  input  logic [MAIN_BITS-1:0]          main_bits,
  input  logic [NUM_CAUSE-1:0]          stg_en,
  input  logic [IE_BITS-1:0]            ien,
  input  logic [NUM_BANK-1:0][DW-1:0]   banks,
  output logic [DW-1:0]                 rdata
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    case (int'(addr))
      RA_MAIN:   sel[MAIN_BITS-1:0] = main_bits;
      RA_STG_EN: sel[NUM_CAUSE-1:0] = stg_en;
      RA_RDY:    sel = banks[0];
      RA_NRDY:   sel = banks[1];
      RA_EMP:    sel = banks[2];
      RA_IRQ_EN: sel[IE_BITS-1:0]   = ien;
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/isr_aggregator.sv
module isr_aggregator
  import isr_pkg::*;
#(
  parameter int N_PIPES = 6,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clk_en,
  input  logic               ev_setup_done,
  input  logic               ev_wr_status,
  input  logic               ev_rd_status,
  input  logic               ev_xfer_done,
  input  logic               ev_seq_err,
  input  logic               ev_setup_pkt,
  input  logic [N_PIPES:0]   ev_rdy,
  input  logic [N_PIPES:0]   ev_nrdy,
  input  logic [N_PIPES:0]   ev_emp,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [N_PIPES:0]   reg_wdata,
  output logic [N_PIPES:0]   reg_rdata,
  output logic               irq,
  output logic               pid_lock
);
  localparam int PW = N_PIPES + 1;

  logic                          main_we;
  logic                          stage_set;
  logic [NUM_CAUSE-1:0]          cause_ev;
  logic [NUM_CAUSE-1:0]          stg_en_q;
  logic [IE_BITS-1:0]            ien_q;
  logic                          stg_q;
  logic                          setup_q;
  logic [NUM_BANK-1:0][PW-1:0]   ev_bank;
  logic [NUM_BANK-1:0][PW-1:0]   pipe_q;
  logic [NUM_BANK-1:0]           bank_we;
  logic [NUM_BANK-1:0]           pipe_sum;
  logic [MAIN_BITS-1:0]          main_bits;
  logic [PW-1:0]                 rdy_q;

  assign main_we = reg_we && (int'(reg_addr) == RA_MAIN);

  always_comb begin
    cause_ev             = '0;
    cause_ev[CS_WR_STS]  = ev_wr_status;
    cause_ev[CS_RD_STS]  = ev_rd_status;
    cause_ev[CS_DONE]    = ev_xfer_done;
    cause_ev[CS_SEQ_ERR] = ev_seq_err;
  end

  isr_stage_gate #(.NC(NUM_CAUSE)) u_gate (
    .setup_ev  (ev_setup_done),
    .cause_ev  (cause_ev),
    .cause_en  (stg_en_q),
    .stage_set (stage_set)
  );

  isr_flag_bank #(.W(1)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .clk_en   (clk_en),
    .set_i    (stage_set),
    .clr_we   (main_we),
    .clr_data (reg_wdata[MB_STAGE]),
    .q        (stg_q)
  );

  isr_flag_bank #(.W(1)) u_setup (
    .clk      (clk),
    .rst      (rst),
    .clk_en   (clk_en),
    .set_i    (ev_setup_pkt),
    .clr_we   (main_we),
    .clr_data (reg_wdata[MB_SETUP]),
    .q        (setup_q)
  );

  assign ev_bank[0] = ev_rdy;
  assign ev_bank[1] = ev_nrdy;
  assign ev_bank[2] = ev_emp;

  for (genvar g = 0; g < NUM_BANK; g++) begin : g_bank
    assign bank_we[g]  = reg_we && (int'(reg_addr) == RA_RDY + g);
    assign pipe_sum[g] = |pipe_q[g];

    isr_flag_bank #(.W(PW)) u_pipe (
      .clk      (clk),
      .rst      (rst),
      .clk_en   (clk_en),
      .set_i    (ev_bank[g]),
      .clr_we   (bank_we[g]),
      .clr_data (reg_wdata),
      .q        (pipe_q[g])
    );
  end

  assign rdy_q = pipe_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_en_q <= '0;
      ien_q    <= '0;
    end else if (reg_we) begin
      if (int'(reg_addr) == RA_STG_EN) stg_en_q <= reg_wdata[NUM_CAUSE-1:0];
      if (int'(reg_addr) == RA_IRQ_EN) ien_q    <= reg_wdata[IE_BITS-1:0];
    end
  end

  always_comb begin
    main_bits           = '0;
    main_bits[MB_STAGE] = stg_q;
    main_bits[MB_RDY]   = pipe_sum[0];
    main_bits[MB_NRDY]  = pipe_sum[1];
    main_bits[MB_EMP]   = pipe_sum[2];
    main_bits[MB_SETUP] = setup_q;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |({pipe_sum, stg_q} & ien_q);
  end

  assign pid_lock = setup_q;

  isr_read_mux #(.AW(ADDR_W), .DW(PW)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .addr      (reg_addr),
    .main_bits (main_bits),
    .stg_en    (stg_en_q),
    .ien       (ien_q),
    .banks     (pipe_q),
    .rdata     (reg_rdata)
  );
endmodule

// File: rtl/isr_aggregator_chk.sv
module isr_aggregator_chk #(
  parameter int PW = 7,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          clk_en,
  input logic          ev_setup_done,
  input logic          ev_wr_status,
  input logic          ev_rd_status,
  input logic          ev_xfer_done,
  input logic          ev_seq_err,
  input logic          ev_setup_pkt,
  input logic          ev_rdy0,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          wdata0,
  input logic          stg_q,
  input logic          setup_q,
  input logic [3:0]    stg_en_q,
  input logic [3:0]    ien_q,
  input logic [PW-1:0] rdy_q,
  input logic          irq,
  input logic          pid_lock
);
  AST_SETUP_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    ev_setup_done |=> stg_q); // R2

  AST_CAUSE_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!stg_q && ev_seq_err && !stg_en_q[3] && !ev_setup_done && !ev_wr_status
     && !ev_rd_status && !ev_xfer_done) |=> !stg_q); // R2

  AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == '0 && wdata0 && stg_q) |=> stg_q); // R3

  AST_STAGE_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && stg_q) |=> stg_q); // R8

  AST_SETUP_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && setup_q) |=> setup_q); // R8

  AST_PIPE_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ((rdy_q & $past(rdy_q)) == $past(rdy_q))); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ev_rdy0 |=> rdy_q[0]); // R10

  AST_PID_LOCK_SET: assert property (@(posedge clk) disable iff (rst)
    ev_setup_pkt |=> pid_lock); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |=> !irq); // R9
endmodule

bind isr_aggregator isr_aggregator_chk #(.PW(PW), .AW(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .clk_en        (clk_en),
  .ev_setup_done (ev_setup_done),
  .ev_wr_status  (ev_wr_status),
  .ev_rd_status  (ev_rd_status),
  .ev_xfer_done  (ev_xfer_done),
  .ev_seq_err    (ev_seq_err),
  .ev_setup_pkt  (ev_setup_pkt),
  .ev_rdy0       (ev_rdy[0]),
  .reg_we        (reg_we),
  .reg_addr      (reg_addr),
  .wdata0        (reg_wdata[0]),
  .stg_q         (stg_q),
  .setup_q       (setup_q),
  .stg_en_q      (stg_en_q),
  .ien_q         (ien_q),
  .rdy_q         (rdy_q),
  .irq           (irq),
  .pid_lock      (pid_lock)
);

// File: tb/tb_isr_aggregator.sv
module tb_isr_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 6;
  localparam int PW = NP + 1;
  localparam int AW = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          rst = 1'b1;
  logic          clk_en = 1'b1;
  logic          ev_setup_done = 0, ev_wr_status = 0, ev_rd_status = 0;
  logic          ev_xfer_done = 0, ev_seq_err = 0, ev_setup_pkt = 0;
  logic [PW-1:0] ev_rdy = '0, ev_nrdy = '0, ev_emp = '0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [PW-1:0] reg_wdata = '0;
  logic [PW-1:0] reg_rdata;
  logic          irq, pid_lock;

  isr_aggregator #(.N_PIPES(NP), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .clk_en(clk_en),
    .ev_setup_done(ev_setup_done), .ev_wr_status(ev_wr_status),
    .ev_rd_status(ev_rd_status), .ev_xfer_done(ev_xfer_done),
    .ev_seq_err(ev_seq_err), .ev_setup_pkt(ev_setup_pkt),
    .ev_rdy(ev_rdy), .ev_nrdy(ev_nrdy), .ev_emp(ev_emp),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .pid_lock(pid_lock)
  );

  // shadow state
  logic          m_stg = 0, m_setup = 0;
  logic [3:0]    m_sen = '0, m_ien = '0;
  logic [PW-1:0] m_rdy = '0, m_nrdy = '0, m_emp = '0;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] model_read(logic [AW-1:0] a);
    case (a)
      3'd0: return {2'b00, m_setup, |m_emp, |m_nrdy, |m_rdy, m_stg};
      3'd1: return {3'b000, m_sen};
      3'd2: return m_rdy;
      3'd3: return m_nrdy;
      3'd4: return m_emp;
      3'd5: return {3'b000, m_ien};
      default: return '0;
    endcase
  endfunction

  function automatic string rd_tag(logic [AW-1:0] a);
    case (a)
      3'd0: return "R5 main read";
      3'd1: return "R2 enable read";
      3'd2, 3'd3, 3'd4: return "R4 pipe read";
      3'd5: return "R9 enable read";
      default: return "R11 unmapped read";
    endcase
  endfunction

  // one clock: compute expectations from state before the edge, advance model
  task automatic step();
    logic          e_irq, clr;
    logic [PW-1:0] e_rd;
    logic [AW-1:0] a;
    logic          n_stg, n_setup;
    logic [3:0]    n_sen, n_ien;
    logic [PW-1:0] n_rdy, n_nrdy, n_emp;
    a   = reg_addr;
    clr = reg_we && clk_en;
    if (rst) begin
      e_irq = 0; e_rd = '0;
      n_stg = 0; n_setup = 0; n_sen = '0; n_ien = '0;
      n_rdy = '0; n_nrdy = '0; n_emp = '0;
    end else begin
      e_irq = |({|m_emp, |m_nrdy, |m_rdy, m_stg} & m_ien);
      e_rd  = model_read(a);
      n_stg = ev_setup_done
            | |({ev_seq_err, ev_xfer_done, ev_rd_status, ev_wr_status} & m_sen)
            | (m_stg & ~(clr && a == 3'd0 && !reg_wdata[0]));
      n_setup = ev_setup_pkt | (m_setup & ~(clr && a == 3'd0 && !reg_wdata[4]));
      n_rdy  = ev_rdy  | (m_rdy  & ~((clr && a == 3'd2) ? ~reg_wdata : '0));
      n_nrdy = ev_nrdy | (m_nrdy & ~((clr && a == 3'd3) ? ~reg_wdata : '0));
      n_emp  = ev_emp  | (m_emp  & ~((clr && a == 3'd4) ? ~reg_wdata : '0));
      n_sen  = (reg_we && a == 3'd1) ? reg_wdata[3:0] : m_sen;
      n_ien  = (reg_we && a == 3'd5) ? reg_wdata[3:0] : m_ien;
    end
    @(posedge clk);
    m_stg = n_stg; m_setup = n_setup; m_sen = n_sen; m_ien = n_ien;
    m_rdy = n_rdy; m_nrdy = n_nrdy; m_emp = n_emp;
    @(negedge clk);
    chk("R9 irq", irq, e_irq);
    chk(rd_tag(a), reg_rdata, e_rd);
    chk("R7 pid_lock", pid_lock, m_setup);
    ev_setup_done = 0; ev_wr_status = 0; ev_rd_status = 0;
    ev_xfer_done = 0; ev_seq_err = 0; ev_setup_pkt = 0;
    ev_rdy = '0; ev_nrdy = '0; ev_emp = '0;
    reg_we = 0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [PW-1:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic rd(logic [AW-1:0] a, logic [PW-1:0] exp, string tag);
    reg_addr = a;
    step();
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    repeat (3) step();
    rst = 0;
    rd(3'd0, 7'h00, "R1 main after reset");
    rd(3'd5, 7'h00, "R1 enables after reset");
    chk("R1 irq after reset", irq, 0);
    chk("R1 pid_lock after reset", pid_lock, 0);

    // R2: masked cause, unmaskable setup completion
    ev_seq_err = 1; step();
    rd(3'd0, 7'h00, "R2 masked cause");
    ev_setup_done = 1; step();
    rd(3'd0, 7'h01, "R2 setup always enabled");
    // R3: write one ignored, write zero clears
    wr(3'd0, 7'h01);
    rd(3'd0, 7'h01, "R3 write one ignored");
    wr(3'd0, 7'h00);
    rd(3'd0, 7'h00, "R3 write zero clears");
    wr(3'd1, 7'h08);
    ev_seq_err = 1; step();
    rd(3'd0, 7'h01, "R2 enabled cause");
    wr(3'd0, 7'h00);

    // R4 / R5
    ev_nrdy = 7'h08; step();
    rd(3'd3, 7'h08, "R4 pipe bit set");
    rd(3'd0, 7'h04, "R5 summary set");
    wr(3'd3, 7'h7F);
    rd(3'd3, 7'h08, "R4 write one keeps");
    wr(3'd0, 7'h00);
    rd(3'd0, 7'h04, "R5 summary not writable");
    wr(3'd3, 7'h77);
    rd(3'd3, 7'h00, "R4 single bit clear");
    rd(3'd0, 7'h00, "R5 summary clears");

    // R6 / R7
    wr(3'd5, 7'h0F);
    ev_setup_pkt = 1; step();
    chk("R7 lock set", pid_lock, 1);
    rd(3'd0, 7'h10, "R6 setup flag set");
    step();
    chk("R6 no irq from setup flag", irq, 0);
    wr(3'd0, 7'h10);
    rd(3'd0, 7'h10, "R6 write one ignored");
    wr(3'd0, 7'h00);
    rd(3'd0, 7'h00, "R6 write zero clears");
    chk("R7 lock released", pid_lock, 0);

    // R8
    ev_rdy = 7'h02; step();
    clk_en = 0;
    wr(3'd2, 7'h00);
    wr(3'd0, 7'h00);
    rd(3'd2, 7'h02, "R8 clear blocked");
    clk_en = 1;
    wr(3'd2, 7'h00);
    rd(3'd2, 7'h00, "R8 clear after enable");

    // R10
    ev_rdy = 7'h01; wr(3'd2, 7'h00);
    rd(3'd2, 7'h01, "R10 set wins");
    wr(3'd2, 7'h00);

    // R9
    wr(3'd5, 7'h02);
    ev_emp = 7'h01; step();
    step();
    chk("R9 masked summary", irq, 0);
    ev_rdy = 7'h04; step();
    step();
    chk("R9 enabled summary", irq, 1);
    wr(3'd2, 7'h00);
    wr(3'd4, 7'h00);
    step();
    chk("R9 deassert", irq, 0);

    // R11
    rd(3'd7, 7'h00, "R11 addr 7");
    rd(3'd6, 7'h00, "R11 addr 6");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      clk_en        = ($urandom_range(9) != 0);
      ev_setup_done = ($urandom_range(15) == 0);
      ev_wr_status  = ($urandom_range(15) == 0);
      ev_rd_status  = ($urandom_range(15) == 0);
      ev_xfer_done  = ($urandom_range(15) == 0);
      ev_seq_err    = ($urandom_range(15) == 0);
      ev_setup_pkt  = ($urandom_range(15) == 0);
      ev_rdy  = PW'($urandom & $urandom & $urandom);
      ev_nrdy = PW'($urandom & $urandom & $urandom);
      ev_emp  = PW'($urandom & $urandom & $urandom);
      reg_we    = ($urandom_range(2) == 0);
      reg_addr  = AW'($urandom);
      reg_wdata = PW'($urandom);
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule